// File: doc/BRIEF.md
# Port Pin Function Multiplexer and Drive Control

This block is the output-steering and input-return logic of a sixteen-pin I/O port. Each pin has five configuration fields: a 2-bit mode, an open-drain flag, a 2-bit pull code and a 4-bit function selector. From these fields, the data bit the port wants to output, and eight peripheral data/enable pairs, the block works out the pad drive value, the pad drive enable, the weak pull-up and pull-down enables and the input-buffer enable for each pin.

Every clock cycle the block samples the pad level into a register, through the input buffer. It returns that level to the port and to the one peripheral input that the pin's selector names. The same selector picks the peripheral output and the peripheral input, so at most one peripheral is attached to a pin. The selectors arrive as two packed words. The low word covers the lower half of the pins and the high word covers the upper half.

Top module: `pinmux_port`

## Requirements
- R1: In mode 10 (peripheral), a selector value s from 0 to 7 connects peripheral s. In push-pull, pad_oe equals that peripheral's enable bit `periph_den[p*8+s]` and pad_out equals its data bit `periph_dout[p*8+s]` while driven.
- R2: A selector value from 8 to 15 connects no peripheral. In mode 10 the pin is not driven, and every `periph_din` bit of that pin is 0.
- R3: Pin p below 8 takes its selector from `sel_lo_word[4p+3:4p]`. Pin p of 8 or more takes it from `sel_hi_word[4(p-8)+3:4(p-8)]`.
- R4: In mode 01 (output), the pin is driven (pad_oe=1) with `port_dout[p]` in push-pull.
- R5: With `odrain_cfg[p]`=1, a pin is driven only when its chosen data is 0. pad_out is then 0, and a data value of 1 leaves pad_oe=0.
- R6: In mode 00 (input), pad_oe=0 and pad_ie=1.
- R7: In mode 11 (analog), pad_oe, pad_pu, pad_pd and pad_ie are all 0. From the next clock edge on, the pin's port_din bit and periph_din bits are 0.
- R8: Outside analog mode, pull code 01 sets pad_pu, code 10 sets pad_pd, and codes 00 and 11 set neither.
- R9: pad_out is 0 whenever pad_oe is 0.
- R10: port_din[p] equals the pad_in[p] value present at the previous rising clock edge, with the input buffer on.
- R11: `periph_din[p*8+s]` carries the sampled level of pin p for the selected s (0..7) and is 0 for every other index.
- R12: While reset is held, port_din and periph_din are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg | input | 32 | 2-bit mode per pin (00 input, 01 output, 10 peripheral, 11 analog) |
| odrain_cfg | input | 16 | Open-drain flag per pin |
| pull_cfg | input | 32 | 2-bit pull code per pin |
| sel_lo_word | input | 32 | Selectors of pins 0 to 7, 4 bits each |
| sel_hi_word | input | 32 | Selectors of pins 8 to 15, 4 bits each |
| port_dout | input | 16 | Port output data bit per pin |
| periph_dout | input | 128 | Peripheral output data, index pin*8+function |
| periph_den | input | 128 | Peripheral drive enable, index pin*8+function |
| pad_in | input | 16 | Pad level per pin |
| pad_out | output | 16 | Pad drive value |
| pad_oe | output | 16 | Pad drive enable |
| pad_pu | output | 16 | Weak pull-up enable |
| pad_pd | output | 16 | Weak pull-down enable |
| pad_ie | output | 16 | Input buffer enable |
| port_din | output | 16 | Sampled pad level for the port |
| periph_din | output | 128 | Sampled pad level returned to the selected peripheral |

## Verification
The pad controls (out, oe, pu, pd, ie) depend only on the current configuration and data, so they take no clock cycles. The bench drives new stimulus on the falling edge and compares these outputs a moment later, before the next rising edge. port_din and periph_din pass through one sample register and are due one rising edge after a pad or mode change. The bench therefore checks them once just after the change, to confirm they still hold the old value, and again at the following falling edge for the new value.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int unsigned SEL_W = 4;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_OUTPUT = 2'b01,
    PM_ALT    = 2'b10,
    PM_ANALOG = 2'b11
  } pin_mode_e;

  // A selector is usable only when it names an existing function.
  function automatic logic sel_in_range(input logic [SEL_W-1:0] sel, input int unsigned nfunc);
    return (32'(sel) < nfunc);
  endfunction

  function automatic logic pull_up_code(input logic [1:0] code);
    return (code == 2'b01);
  endfunction

  function automatic logic pull_dn_code(input logic [1:0] code);
    return (code == 2'b10);
  endfunction

endpackage

// File: rtl/pin_cell.sv
module pin_cell
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_FUNCS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 odrain,
  input  logic [1:0]           pull,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 port_bit,
  input  logic [NUM_FUNCS-1:0] fn_dout,
  input  logic [NUM_FUNCS-1:0] fn_den,
  input  logic                 in_sample,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 pad_pu,
  output logic                 pad_pd,
  output logic                 pad_ie,
  output logic [NUM_FUNCS-1:0] fn_din
);

  pin_mode_e pmode;
  logic      fn_valid;
  logic      af_data;
  logic      af_en;
  logic      drv_data;
  logic      drv_en;
  logic      digital_on;

  assign pmode      = pin_mode_e'(mode);
  assign fn_valid   = sel_in_range(sel, NUM_FUNCS);
  assign digital_on = (pmode != PM_ANALOG);

  always_comb begin
    af_data = 1'b0;
    af_en   = 1'b0;
    for (int f = 0; f < int'(NUM_FUNCS); f++) begin
      if (fn_valid && (32'(sel) == f)) begin
        af_data = fn_dout[f];
        af_en   = fn_den[f];
      end
    end
  end

  always_comb begin
    drv_data = 1'b0;
    drv_en   = 1'b0;
    case (pmode)
      PM_OUTPUT: begin drv_data = port_bit; drv_en = 1'b1;  end
      PM_ALT:    begin drv_data = af_data;  drv_en = af_en; end
      default:   begin drv_data = 1'b0;     drv_en = 1'b0;  end
    endcase
  end

  assign pad_oe  = drv_en && (!odrain || !drv_data);
  assign pad_out = drv_en && !odrain && drv_data;
  assign pad_pu  = digital_on && pull_up_code(pull);
  assign pad_pd  = digital_on && pull_dn_code(pull);
  assign pad_ie  = digital_on;

  always_comb begin
    for (int f = 0; f < int'(NUM_FUNCS); f++)
      fn_din[f] = fn_valid && (32'(sel) == f) && in_sample;
  end

  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (!pad_oe && !pad_pu && !pad_pd && !pad_ie)); // R7
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (!pad_oe && pad_ie)); // R6
  AST_RESERVED_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b10) && !fn_valid) |-> (!pad_oe && (fn_din == '0))); // R2
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    odrain |-> !pad_out); // R5
  AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> !pad_out); // R9
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_pu && pad_pd)); // R8
  AST_RETURN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fn_din)); // R11

endmodule

// File: rtl/in_sampler.sv
module in_sampler #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_level,
  input  logic [WIDTH-1:0] buf_en,
  output logic [WIDTH-1:0] sampled
);

  logic [WIDTH-1:0] gated;
  assign gated = pad_level & buf_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sampled <= '0;
    else        sampled <= gated;
  end

  AST_BUFFER_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en == '0) |=> (sampled == '0)); // R7

endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 16,
  parameter int unsigned NUM_FUNCS = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [2*NUM_PINS-1:0]              mode_cfg,
  input  logic [NUM_PINS-1:0]                odrain_cfg,
  input  logic [2*NUM_PINS-1:0]              pull_cfg,
  input  logic [(NUM_PINS/2)*SEL_W-1:0]      sel_lo_word,
  input  logic [(NUM_PINS/2)*SEL_W-1:0]      sel_hi_word,
  input  logic [NUM_PINS-1:0]                port_dout,
  input  logic [NUM_PINS*NUM_FUNCS-1:0]      periph_dout,
  input  logic [NUM_PINS*NUM_FUNCS-1:0]      periph_den,
  input  logic [NUM_PINS-1:0]                pad_in,
  output logic [NUM_PINS-1:0]                pad_out,
  output logic [NUM_PINS-1:0]                pad_oe,
  output logic [NUM_PINS-1:0]                pad_pu,
  output logic [NUM_PINS-1:0]                pad_pd,
  output logic [NUM_PINS-1:0]                pad_ie,
  output logic [NUM_PINS-1:0]                port_din,
  output logic [NUM_PINS*NUM_FUNCS-1:0]      periph_din
);

  localparam int unsigned HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] sample_q;

  in_sampler #(.WIDTH(NUM_PINS)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_level (pad_in),
    .buf_en    (pad_ie),
    .sampled   (sample_q)
  );

  assign port_din = sample_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0] pin_sel;
    if (p < HALF) begin : g_lo
      assign pin_sel = sel_lo_word[p*SEL_W +: SEL_W];
    end else begin : g_hi
      assign pin_sel = sel_hi_word[(p-HALF)*SEL_W +: SEL_W];
    end

    pin_cell #(.NUM_FUNCS(NUM_FUNCS)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_cfg[2*p +: 2]),
      .odrain    (odrain_cfg[p]),
      .pull      (pull_cfg[2*p +: 2]),
      .sel       (pin_sel),
      .port_bit  (port_dout[p]),
      .fn_dout   (periph_dout[p*NUM_FUNCS +: NUM_FUNCS]),
      .fn_den    (periph_den[p*NUM_FUNCS +: NUM_FUNCS]),
      .in_sample (sample_q[p]),
      .pad_out   (pad_out[p]),
      .pad_oe    (pad_oe[p]),
      .pad_pu    (pad_pu[p]),
      .pad_pd    (pad_pd[p]),
      .pad_ie    (pad_ie[p]),
      .fn_din    (periph_din[p*NUM_FUNCS +: NUM_FUNCS])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rst_n ? (port_din == '0 && periph_din == '0) : 1'b1)); // R12
  AST_DIN_FOLLOWS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((port_din & ~$past(pad_in)) == '0)); // R10

endmodule

// File: tb/test_pinmux_port.sv
module test_pinmux_port;
  localparam int N = 16;
  localparam int F = 8;
  localparam int NV = 18;

  // {mode, od, pull, sel, fn_data, fn_en, port_bit, exp_out, exp_oe, exp_pu, exp_pd, exp_ie}
  localparam logic [16:0] VEC [NV] = '{
    17'b00_0_00_0000_1_1_1_0_0_0_0_1,
    17'b00_0_01_0000_1_1_1_0_0_1_0_1,
    17'b00_0_10_0000_1_1_1_0_0_0_1_1,
    17'b00_0_11_0000_1_1_1_0_0_0_0_1,
    17'b01_0_00_0000_0_0_1_1_1_0_0_1,
    17'b01_0_00_0000_1_1_0_0_1_0_0_1,
    17'b01_1_00_0000_0_0_1_0_0_0_0_1,
    17'b01_1_00_0000_1_1_0_0_1_0_0_1,
    17'b10_0_00_0011_1_1_0_1_1_0_0_1,
    17'b10_0_00_0011_0_1_1_0_1_0_0_1,
    17'b10_0_00_0111_1_0_1_0_0_0_0_1,
    17'b10_1_00_0010_1_1_0_0_0_0_0_1,
    17'b10_1_00_0010_0_1_1_0_1_0_0_1,
    17'b10_0_00_1000_0_0_1_0_0_0_0_1,
    17'b10_0_00_1111_0_0_1_0_0_0_0_1,
    17'b11_0_01_0000_1_1_1_0_0_0_0_0,
    17'b11_1_10_0000_1_1_0_0_0_0_0_0,
    17'b10_0_01_0000_1_1_0_1_1_1_0_1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*N-1:0] mode_cfg = '0;
  logic [N-1:0]   odrain_cfg = '0;
  logic [2*N-1:0] pull_cfg = '0;
  logic [31:0]    sel_lo_word = '0;
  logic [31:0]    sel_hi_word = '0;
  logic [N-1:0]   port_dout = '0;
  logic [N*F-1:0] periph_dout = '0;
  logic [N*F-1:0] periph_den = '0;
  logic [N-1:0]   pad_in = '0;
  logic [N-1:0]   pad_out, pad_oe, pad_pu, pad_pd, pad_ie, port_din;
  logic [N*F-1:0] periph_din;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pinmux_port i_pinmux_port (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .odrain_cfg(odrain_cfg),
    .pull_cfg(pull_cfg), .sel_lo_word(sel_lo_word), .sel_hi_word(sel_hi_word),
    .port_dout(port_dout), .periph_dout(periph_dout), .periph_den(periph_den),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_ie(pad_ie), .port_din(port_din), .periph_din(periph_din)
  );

  task automatic check(input string req, input logic [N*F-1:0] act, input logic [N*F-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sel_of(input int p);
    if (p < 8) return int'(sel_lo_word[4*p +: 4]);
    return int'(sel_hi_word[4*(p-8) +: 4]);
  endfunction

  initial begin
    logic [N*F-1:0] exp_ret;
    logic [N-1:0] exp_out;
    // R12: reset holds the sampled paths at zero
    pad_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 port_din in reset", 128'(port_din), '0);
    check("R12 periph_din in reset", periph_din, '0);
    check("R6 default input mode oe", 128'(pad_oe), '0);
    rst_n = 1'b1;
    pad_in = '0;
    @(negedge clk);

    // Table of single-configuration vectors applied to every pin
    for (int v = 0; v < NV; v++) begin
      logic [16:0] e;
      logic [3:0] s;
      string tag;
      e = VEC[v];
      s = e[11:8];
      mode_cfg   = {N{e[16:15]}};
      odrain_cfg = {N{e[14]}};
      pull_cfg   = {N{e[13:12]}};
      sel_lo_word = {8{s}};
      sel_hi_word = {8{s}};
      port_dout  = {N{e[5]}};
      for (int p = 0; p < N; p++)
        for (int f = 0; f < F; f++) begin
          periph_dout[p*F+f] = (f == int'(s)) ? e[7] : ~e[7];
          periph_den[p*F+f]  = (f == int'(s)) ? e[6] : ~e[6];
        end
      #1;
      case (e[16:15])
        2'b00: tag = "R6";
        2'b01: tag = e[14] ? "R5" : "R4";
        2'b10: tag = s[3] ? "R2" : (e[14] ? "R5" : "R1");
        default: tag = "R7";
      endcase
      check($sformatf("%s vec%0d oe", tag, v), 128'(pad_oe), 128'({N{e[3]}}));
      check($sformatf("%s vec%0d out", e[3] ? tag : "R9", v), 128'(pad_out), 128'({N{e[4]}}));
      check($sformatf("%s vec%0d pulls", (e[16:15] == 2'b11) ? "R7" : "R8", v),
            128'({pad_pu, pad_pd}), 128'({{N{e[2]}}, {N{e[1]}}}));
      check($sformatf("%s vec%0d ie", (e[16:15] == 2'b11) ? "R7" : "R6", v),
            128'(pad_ie), 128'({N{e[0]}}));
      @(negedge clk);
    end

    // R3: per-pin selector placement in the two words, pin 11 reserved
    mode_cfg = {N{2'b10}};
    odrain_cfg = '0;
    pull_cfg = '0;
    sel_lo_word = 32'h7654_3210;
    sel_hi_word = 32'h0123_A567;
    periph_den = '1;
    for (int p = 0; p < N; p++)
      for (int f = 0; f < F; f++)
        periph_dout[p*F+f] = (f == sel_of(p));
    #1;
    check("R3 per-pin selector out", 128'(pad_out), 128'(16'hF7FF));
    check("R2 reserved pin undriven", 128'(pad_oe), 128'(16'hF7FF));

    // R10/R11: one-cycle sampling latency and return steering
    @(negedge clk);
    pad_in = 16'hA5C3;
    #1;
    check("R10 port_din before edge", 128'(port_din), '0);
    @(negedge clk);
    check("R10 port_din after edge", 128'(port_din), 128'(16'hA5C3));
    exp_ret = '0;
    for (int p = 0; p < N; p++)
      if (sel_of(p) < F) exp_ret[p*F + sel_of(p)] = pad_in[p];
    check("R11 periph_din steering", periph_din, exp_ret);

    // R7: analog pin reads back 0 from the next edge
    mode_cfg[1:0] = 2'b11;
    @(negedge clk);
    check("R7 analog port_din", 128'(port_din), 128'(16'hA5C2));
    exp_ret[0] = 1'b0;
    check("R7 analog periph_din", periph_din, exp_ret);

    // R4/R5: output mode push-pull vs open-drain per pin
    mode_cfg = {N{2'b01}};
    odrain_cfg = 16'hFF00;
    port_dout = 16'h0F0F;
    #1;
    exp_out = 16'h000F;
    check("R4 mixed output drive", 128'(pad_out), 128'(exp_out));
    check("R5 mixed output enable", 128'(pad_oe), 128'(16'hF0FF));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule